// File: doc/BRIEF.md
# Fuse Array Control and Status Register Engine

This block is the register front end of a one-time-programmable fuse store of 128 words, each 32 bits wide. Software talks to it over a single-cycle register port. The port has a control word, two alias addresses that set or clear bits in that word, a free timing word, a data word, and a window of shadow copies of the fuse words. The block runs three kinds of access, one at a time. A shadow read returns a cached word. A program operation ORs the data word into one fuse word. A reload refreshes every shadow copy from the fuses.

Programming is guarded by a key. The key goes into the upper half of the control word together with the target address, and it is consumed by the write to the data word that starts the operation. Each fuse word carries a program-lock bit and a read-lock bit, both supplied as input vectors.

A request that breaks a lock does not reach the fuse store; it raises a sticky error flag instead. A request made while an operation is running is dropped and also raises the flag. While the flag is up, the block accepts no new request until software clears the flag through the clear alias.

Top module: `otp_fuse_regs`

## Requirements
- R1: After reset the control word, timing word, data word, every shadow word and every fuse word read as zero.
- R2: The control word sits at offset 0x000, the set alias at 0x004, the clear alias at 0x008, timing at 0x010 and data at 0x020. Shadow word n is read and written at 0x400 + 16*n. The control word holds the target address in bits [6:0], busy in bit 8, error in bit 9, reload-in-progress in bit 10 and the key in bits [31:16]. Any other offset reads zero and ignores writes.
- R3: A write to the set alias ORs the written value into the address and key fields. A write to the clear alias clears the address and key bits that are 1 in the written value, and it clears the error flag when bit 9 is 1. Both aliases read back the control word.
- R4: A data write while the key field holds 0x3E77 and the flag is clear starts programming. Busy then reads 1 for PROG_CYCLES cycles and the key field reads 0 from the next cycle. A data write without the key only stores the value.
- R5: Programming targets the address held when it started; address writes during the operation do not redirect it.
- R6: A finished program operation ORs the data word into the fuse word, and the result becomes visible in the shadow window after a reload.
- R7: A keyed data write to a program-locked word starts nothing and leaves busy at 0. It sets the error flag and clears the key.
- R8: Reading a read-locked shadow word returns 0xBADABADA and sets the error flag.
- R9: While the error flag is set, a shadow read returns 0 and changes nothing, and program, reload and shadow-write requests are ignored. After the flag is cleared, requests are accepted again.
- R10: When idle and error-free, a shadow write stores the value. A shadow write to a program-locked word, or one made while busy, sets the error flag and leaves the word unchanged.
- R11: Writing 1 to bit 10 through the control word or the set alias starts a reload. Bit 10 and busy then read 1 for NWORDS cycles, every shadow word takes its fuse value, and both bits clear by themselves.
- R12: A data write, reload request, shadow read or shadow write made while busy is ignored and sets the error flag.
- R13: The timing word stores and returns any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers read side effects) |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| word_prog_lock | input | 128 | Per-word program lock |
| word_read_lock | input | 128 | Per-word read lock |

## Verification
The hardest cases to reach from the ports are requests that arrive while the engine is occupied. A reload keeps the block busy for 128 cycles, and a program operation keeps it busy for eight. The stimulus therefore issues shadow writes, data writes and address rewrites inside those windows. It then checks that the running operation completes unchanged and still lands on the address captured at its start. A keyed program attempt is also made while the error flag is up; it must stay inert, and the same armed key must start programming once the flag is cleared.

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs #(
  parameter int NWORDS      = 128,
  parameter int AW          = 12,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NWORDS-1:0] word_prog_lock,
  input  logic [NWORDS-1:0] word_read_lock
);

  localparam int IW       = $clog2(NWORDS);
  localparam int CW       = $clog2(PROG_CYCLES + 1);
  localparam int OFS_CTRL = 'h000;
  localparam int OFS_SET  = 'h004;
  localparam int OFS_CLR  = 'h008;
  localparam int OFS_TIM  = 'h010;
  localparam int OFS_DATA = 'h020;
  localparam int WIN_LO   = 'h400;
  localparam int WIN_HI   = WIN_LO + NWORDS * 16;
  localparam logic [15:0] KEY    = 16'h3E77;
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  logic [IW-1:0] addr_q, paddr_q, ridx_q;
  logic [15:0]   key_q;
  logic          err_q, prog_q, rel_q;
  logic [CW-1:0] pcnt_q;
  logic [31:0]   timing_q, data_q;
  logic [31:0]   fuse_q   [NWORDS];
  logic [31:0]   shadow_q [NWORDS];

  wire busy = prog_q | rel_q;

  wire [31:0] a32      = 32'(bus_addr);
  wire        hit_ctrl = a32 == 32'(OFS_CTRL);
  wire        hit_set  = a32 == 32'(OFS_SET);
  wire        hit_clr  = a32 == 32'(OFS_CLR);
  wire        hit_tim  = a32 == 32'(OFS_TIM);
  wire        hit_data = a32 == 32'(OFS_DATA);
  wire        in_win   = (a32 >= 32'(WIN_LO)) && (a32 < 32'(WIN_HI)) && (a32[3:0] == 4'd0);
  wire [31:0] win_ofs  = (a32 - 32'(WIN_LO)) >> 4;
  wire [IW-1:0] win_idx = win_ofs[IW-1:0];

  wire rel_req  = bus_wr & (hit_ctrl | hit_set) & bus_wdata[10];
  wire data_wr  = bus_wr & hit_data;
  wire sh_wr    = bus_wr & in_win;
  wire sh_rd    = bus_rd & in_win;
  wire armed    = key_q == KEY;

  wire busy_hit = busy & (rel_req | data_wr | sh_wr | sh_rd);
  wire open_q   = ~busy & ~err_q;
  wire rel_go   = rel_req & open_q;
  wire prog_ok  = data_wr & armed & open_q;
  wire prog_go  = prog_ok & ~word_prog_lock[addr_q];
  wire lock_hit = prog_ok & word_prog_lock[addr_q];
  wire sh_ok    = sh_wr & open_q;
  wire sh_bad   = sh_ok & word_prog_lock[win_idx];
  wire sh_go    = sh_ok & ~word_prog_lock[win_idx];
  wire rd_bad   = sh_rd & open_q & word_read_lock[win_idx];
  wire err_set  = busy_hit | lock_hit | sh_bad | rd_bad;
  wire err_clr  = bus_wr & hit_clr & bus_wdata[9];

  wire [31:0] ctrl_word = {key_q, 5'd0, rel_q, err_q, busy, {(8 - IW){1'b0}}, addr_q};

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl | hit_set | hit_clr) bus_rdata = ctrl_word;
    else if (hit_tim)                 bus_rdata = timing_q;
    else if (hit_data)                bus_rdata = data_q;
    else if (in_win) begin
      if (busy | err_q)                  bus_rdata = '0;
      else if (word_read_lock[win_idx])  bus_rdata = POISON;
      else                               bus_rdata = shadow_q[win_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      key_q    <= '0;
      err_q    <= 1'b0;
      timing_q <= '0;
      data_q   <= '0;
    end else begin
      if (bus_wr & hit_ctrl) begin
        addr_q <= bus_wdata[IW-1:0];
        key_q  <= bus_wdata[31:16];
      end else if (bus_wr & hit_set) begin
        addr_q <= addr_q | bus_wdata[IW-1:0];
        key_q  <= key_q | bus_wdata[31:16];
      end else if (bus_wr & hit_clr) begin
        addr_q <= addr_q & ~bus_wdata[IW-1:0];
        key_q  <= key_q & ~bus_wdata[31:16];
      end else if (prog_go | lock_hit) begin
        key_q  <= '0;
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (bus_wr & hit_tim)  timing_q <= bus_wdata;
      if (data_wr & ~busy)   data_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      rel_q   <= 1'b0;
      pcnt_q  <= '0;
      paddr_q <= '0;
      ridx_q  <= '0;
      for (int i = 0; i < NWORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (prog_go) begin
        prog_q  <= 1'b1;
        pcnt_q  <= CW'(PROG_CYCLES - 1);
        paddr_q <= addr_q;
      end else if (prog_q) begin
        if (pcnt_q == '0) begin
          prog_q          <= 1'b0;
          fuse_q[paddr_q] <= fuse_q[paddr_q] | data_q;
        end else begin
          pcnt_q <= pcnt_q - 1'b1;
        end
      end
      if (rel_go) begin
        rel_q  <= 1'b1;
        ridx_q <= '0;
      end else if (rel_q) begin
        shadow_q[ridx_q] <= fuse_q[ridx_q];
        ridx_q           <= ridx_q + 1'b1;
        if (ridx_q == IW'(NWORDS - 1)) rel_q <= 1'b0;
      end
      if (sh_go) shadow_q[win_idx] <= bus_wdata;
    end
  end

  p_prog_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_data && key_q == KEY && !busy && !err_q && !word_prog_lock[addr_q])
    |=> (busy && key_q == 16'h0));

  p_addr_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && $past(prog_q)) |-> $stable(paddr_q));

  p_lock_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_data && key_q == KEY && !busy && !err_q && word_prog_lock[addr_q])
    |=> (err_q && !busy));

  p_poison_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_win && !busy && !err_q && word_read_lock[win_idx])
    |-> (bus_rdata == POISON) ##1 err_q);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(bus_wr && hit_clr && bus_wdata[9])) |=> err_q);

  p_reload_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> (ridx_q == '0 && !prog_q));

  p_single_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_q && rel_q));

endmodule

// File: tb/test_otp_fuse_regs.sv
module test_otp_fuse_regs;
  localparam int N    = 128;
  localparam int PROG = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] plk = '0, rlk = '0;

  otp_fuse_regs #(.NWORDS(N), .AW(12), .PROG_CYCLES(PROG)) i_otp_fuse_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_prog_lock(plk), .word_read_lock(rlk));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string ph = "R1";

  logic [6:0]  m_addr;
  logic [15:0] m_key;
  logic        m_err;
  logic [31:0] m_tim, m_data;
  logic [31:0] m_fuse [N];
  logic [31:0] m_shadow [N];
  int          m_pleft, m_paddr, m_ridx;
  bit          b, e, relq, inw;
  int          ix;

  function automatic bit win(input logic [11:0] a);
    return (a >= 12'h400) && (int'(a) < 'h400 + N * 16) && (a[3:0] == 4'd0);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    bit bz = (m_pleft > 0) || (m_ridx >= 0);
    int i;
    if (a == 12'h000 || a == 12'h004 || a == 12'h008)
      return {m_key, 5'd0, m_ridx >= 0, m_err, bz, 1'b0, m_addr};
    if (a == 12'h010) return m_tim;
    if (a == 12'h020) return m_data;
    if (win(a)) begin
      i = (int'(a) - 'h400) / 16;
      if (bz || m_err) return 32'h0;
      if (rlk[i]) return 32'hBADA_BADA;
      return m_shadow[i];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_addr = '0; m_key = '0; m_err = 0; m_tim = '0; m_data = '0;
      m_pleft = 0; m_paddr = 0; m_ridx = -1;
      for (int i = 0; i < N; i++) begin m_fuse[i] = '0; m_shadow[i] = '0; end
    end else begin
      b = (m_pleft > 0) || (m_ridx >= 0);
      e = m_err;
      if (m_pleft > 0) begin
        m_pleft--;
        if (m_pleft == 0) m_fuse[m_paddr] = m_fuse[m_paddr] | m_data;
      end
      if (m_ridx >= 0) begin
        m_shadow[m_ridx] = m_fuse[m_ridx];
        m_ridx++;
        if (m_ridx == N) m_ridx = -1;
      end
      relq = 0;
      inw  = win(bus_addr);
      ix   = (int'(bus_addr) - 'h400) / 16;
      if (bus_wr) begin
        if (bus_addr == 12'h000) begin
          m_addr = bus_wdata[6:0]; m_key = bus_wdata[31:16]; relq = bus_wdata[10];
        end else if (bus_addr == 12'h004) begin
          m_addr |= bus_wdata[6:0]; m_key |= bus_wdata[31:16]; relq = bus_wdata[10];
        end else if (bus_addr == 12'h008) begin
          m_addr &= ~bus_wdata[6:0]; m_key &= ~bus_wdata[31:16];
          if (bus_wdata[9]) m_err = 0;
        end else if (bus_addr == 12'h010) begin
          m_tim = bus_wdata;
        end else if (bus_addr == 12'h020) begin
          if (b) m_err = 1;
          else begin
            m_data = bus_wdata;
            if (m_key == 16'h3E77 && !e) begin
              m_key = '0;
              if (plk[m_addr]) m_err = 1;
              else begin m_pleft = PROG; m_paddr = int'(m_addr); end
            end
          end
        end else if (inw) begin
          if (b) m_err = 1;
          else if (!e) begin
            if (plk[ix]) m_err = 1;
            else m_shadow[ix] = bus_wdata;
          end
        end
        if (relq) begin
          if (b) m_err = 1;
          else if (!e) m_ridx = 0;
        end
      end else if (bus_rd && inw) begin
        if (b) m_err = 1;
        else if (!e && rlk[ix]) m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [31:0] x;
      x = exp_rd(bus_addr);
      checks++;
      if (bus_rdata !== x) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", ph, bus_addr, bus_rdata, x);
      end
    end
  end

  task automatic op(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<20000 cycles", cyc);
    finish_run();
  end

  initial begin
    plk[5] = 1'b1;
    rlk[9] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    ph = "R1"; idle(2);
    op(0, 0, 12'h010, 0); op(0, 0, 12'h020, 0); op(0, 0, 12'h400, 0); op(0, 0, 12'h4F0, 0);
    ph = "R13"; op(1, 0, 12'h010, 32'h0ABC_1234); op(0, 0, 12'h010, 0);
    ph = "R2"; op(1, 0, 12'h044, 32'hFFFF_FFFF); op(0, 0, 12'h044, 0); op(0, 0, 12'h404, 0);
    ph = "R3"; op(1, 0, 12'h004, 32'h0001_0042); op(1, 0, 12'h004, 32'h0002_0011);
    op(1, 0, 12'h008, 32'h0001_0003); op(0, 0, 12'h008, 0); op(1, 0, 12'h008, 32'hFFFF_FFFF);
    ph = "R4"; op(1, 0, 12'h000, 32'h3E77_0003); op(1, 0, 12'h020, 32'h0000_00A5);
    ph = "R5"; op(1, 0, 12'h000, 32'h0000_0007); idle(10);
    ph = "R4"; op(1, 0, 12'h020, 32'h0000_FFFF); idle(3);
    op(1, 0, 12'h020, 32'h0000_0000);
    ph = "R11"; op(1, 0, 12'h004, 32'h0000_0400);
    ph = "R10"; op(1, 0, 12'h430, 32'h1234_5678);
    ph = "R9"; op(1, 0, 12'h008, 32'h0000_0200);
    ph = "R12"; op(1, 0, 12'h020, 32'h0000_0005); op(0, 1, 12'h410, 0);
    op(1, 0, 12'h008, 32'h0000_0200);
    ph = "R11"; idle(130);
    ph = "R6"; op(0, 1, 12'h430, 0);
    op(1, 0, 12'h000, 32'h3E77_0003); op(1, 0, 12'h020, 32'h0000_5A00);
    ph = "R12"; op(1, 0, 12'h000, 32'h0000_0400); op(1, 0, 12'h008, 32'h0000_0200); idle(10);
    ph = "R11"; op(1, 0, 12'h000, 32'h0000_0400); idle(130);
    ph = "R6"; op(0, 1, 12'h430, 0);
    ph = "R7"; op(1, 0, 12'h000, 32'h3E77_0005); op(1, 0, 12'h020, 32'h0000_0001); idle(3);
    op(1, 0, 12'h008, 32'h0000_0200);
    ph = "R8"; op(0, 1, 12'h490, 0); idle(2);
    ph = "R9"; op(1, 0, 12'h000, 32'h3E77_0002); op(1, 0, 12'h020, 32'h0000_0077);
    op(1, 0, 12'h004, 32'h0000_0400); op(0, 1, 12'h430, 0); op(1, 0, 12'h4A0, 32'h1);
    op(1, 0, 12'h008, 32'h0000_0200); op(1, 0, 12'h020, 32'h0000_0077); idle(10);
    ph = "R10"; op(1, 0, 12'h4A0, 32'hCAFE_F00D); op(0, 1, 12'h4A0, 0);
    op(1, 0, 12'h450, 32'h0000_0001); op(1, 0, 12'h008, 32'h0000_0200); op(0, 1, 12'h450, 0);
    ph = "R11"; op(1, 0, 12'h004, 32'h0000_0400); idle(130);
    ph = "R6"; op(0, 1, 12'h420, 0); op(0, 1, 12'h4A0, 0); op(0, 1, 12'h430, 0);
    idle(3);
    finish_run();
  end
endmodule